// File: doc/BRIEF.md
# UART Baud Rate Generator

This block turns a fast reference clock into the timing strobes that a UART channel needs to send and sample serial bits. It produces no derived clock. It emits two single-cycle enables in the system clock domain. The first is a sample tick at the oversampling rate. The second is a bit tick that marks the end of each bit period.

The sample rate is set by three things. A 16-bit divisor arrives as a high byte and a low byte. A select input can insert a divide-by-4 stage ahead of the divisor. A mode input picks 16 or 8 sample ticks per bit; the 8x choice doubles the data rate for the same divisor.

A write strobe for either divisor byte restarts the whole timing chain, so the new rate takes effect from the next tick. The register bus that writes the bytes lives outside this block. So do the receiver and the transmitter that consume the ticks.

Top module: `uart_baud_gen`

## Requirements
- R1: While `rst` is high, and in the cycle after a reset edge, both `sample_tick` and `bit_tick` are 0.
- R2: With `pre_div4`=0, `sample_tick` pulses once every D clock cycles, where D = {`div_hi`,`div_lo`} and the high byte supplies bits 15:8.
- R3: With `pre_div4`=1, `sample_tick` pulses once every 4*D clock cycles.
- R4: A divisor of 0x0000 behaves exactly like a divisor of 1, so the tick never stalls.
- R5: With `os_8x`=0, `bit_tick` is high on every 16th `sample_tick`, counted from the last restart.
- R6: With `os_8x`=1, `bit_tick` is high on every 8th `sample_tick`, counted from the last restart.
- R7: A clock edge with `div_hi_we` or `div_lo_we` high restarts the chain. Neither tick is high in the following cycle. The first `sample_tick` is high exactly P cycles after that edge, where P is the period from R2 or R3, and the bit grouping restarts at that tick.
- R8: `bit_tick` is never high unless `sample_tick` is high in the same cycle.
- R9: All 16 divisor bits take part. For example, 0x0900 gives a sample period of 2304 cycles and 0x0018 gives 24 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference / system clock |
| rst | input | 1 | Synchronous active-high reset |
| div_hi | input | 8 | Divisor high byte (bits 15:8) |
| div_lo | input | 8 | Divisor low byte (bits 7:0) |
| div_hi_we | input | 1 | High-byte write strobe; restarts the timing chain |
| div_lo_we | input | 1 | Low-byte write strobe; restarts the timing chain |
| pre_div4 | input | 1 | 1 inserts the divide-by-4 stage, 0 bypasses it |
| os_8x | input | 1 | 1 selects 8 samples per bit, 0 selects 16 |
| sample_tick | output | 1 | One-cycle enable at the oversampling rate |
| bit_tick | output | 1 | One-cycle enable on the sample tick that ends a bit |

## Verification
Some properties are checked on every cycle:
- reset quiets both outputs;
- a byte write suppresses the next cycle's ticks;
- `bit_tick` only appears together with `sample_tick`;
- no group ever runs past 16 sample ticks without a bit tick;
- a divisor of 0 or 1, with no stage in front of it, yields a tick on every cycle.

Other behaviour needs the bench's scenarios:
- the exact sample period for each prescaler and divisor setting, including the full 16-bit reference values;
- the phase of the first tick after a restart;
- whether bit ticks fall on every 8th or every 16th sample.

// File: rtl/baud_pkg.sv
package baud_pkg;
  localparam int DIV_W     = 16;
  localparam int BYTE_W    = 8;
  localparam int PRE_RATIO = 4;
  localparam int OS_WIDE   = 16;
  localparam int OS_NARROW = 8;

  typedef enum logic {
    OS_X16 = 1'b0,
    OS_X8  = 1'b1
  } os_mode_e;
endpackage

// File: rtl/brg_prescaler.sv
module brg_prescaler #(
  parameter int RATIO = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic enable_div,
  output logic pre_en
);
  localparam int CW = (RATIO > 1) ? $clog2(RATIO) : 1;
  localparam logic [CW-1:0] LAST = CW'(RATIO - 1);

  logic [CW-1:0] pcnt;

  assign pre_en = enable_div ? (pcnt == LAST) : 1'b1;

  always_ff @(posedge clk) begin
    if (rst || restart || !enable_div) begin
      pcnt <= '0;
    end else if (pcnt == LAST) begin
      pcnt <= '0;
    end else begin
      pcnt <= pcnt + 1'b1;
    end
  end
endmodule

// File: rtl/brg_divider.sv
module brg_divider #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         restart,
  input  logic         pre_en,
  input  logic [W-1:0] divisor,
  output logic         fire
);
  logic [W-1:0] cnt;
  logic [W-1:0] eff_m1;
  logic         at_end;

  // A zero divisor is promoted to one: its terminal count is also zero.
  assign eff_m1 = (divisor == '0) ? '0 : divisor - 1'b1;
  assign at_end = (cnt >= eff_m1);
  assign fire   = pre_en && at_end && !restart;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt <= '0;
    end else if (pre_en) begin
      cnt <= at_end ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/brg_bitcount.sv
module brg_bitcount #(
  parameter int WIDE   = 16,
  parameter int NARROW = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic fire,
  input  logic narrow,
  output logic bit_tick
);
  localparam int BW = $clog2(WIDE);

  logic [BW-1:0] bcnt;
  logic [BW-1:0] last;
  logic          wrap;

  assign last = narrow ? BW'(NARROW - 1) : BW'(WIDE - 1);
  assign wrap = (bcnt >= last);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      bcnt     <= '0;
      bit_tick <= 1'b0;
    end else begin
      bit_tick <= fire && wrap;
      if (fire) begin
        bcnt <= wrap ? '0 : bcnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/uart_baud_gen.sv
module uart_baud_gen
  import baud_pkg::*;
#(
  parameter int DW     = DIV_W,
  parameter int BW     = BYTE_W,
  parameter int PRE    = PRE_RATIO,
  parameter int OS_HI  = OS_WIDE,
  parameter int OS_LO  = OS_NARROW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [BW-1:0] div_hi,
  input  logic [BW-1:0] div_lo,
  input  logic          div_hi_we,
  input  logic          div_lo_we,
  input  logic          pre_div4,
  input  logic          os_8x,
  output logic          sample_tick,
  output logic          bit_tick
);
  localparam int HI_W = DW - BW;

  logic          restart;
  logic          pre_en;
  logic          fire;
  logic [DW-1:0] divisor;
  os_mode_e      mode;

  assign restart = div_hi_we || div_lo_we;
  assign divisor = {div_hi[HI_W-1:0], div_lo};
  assign mode    = os_mode_e'(os_8x);

  brg_prescaler #(.RATIO(PRE)) u_pre (
    .clk        (clk),
    .rst        (rst),
    .restart    (restart),
    .enable_div (pre_div4),
    .pre_en     (pre_en)
  );

  brg_divider #(.W(DW)) u_div (
    .clk     (clk),
    .rst     (rst),
    .restart (restart),
    .pre_en  (pre_en),
    .divisor (divisor),
    .fire    (fire)
  );

  brg_bitcount #(.WIDE(OS_HI), .NARROW(OS_LO)) u_bit (
    .clk      (clk),
    .rst      (rst),
    .restart  (restart),
    .fire     (fire),
    .narrow   (mode == OS_X8),
    .bit_tick (bit_tick)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sample_tick <= 1'b0;
    end else begin
      sample_tick <= fire;
    end
  end
endmodule

// File: rtl/uart_baud_gen_chk.sv
module uart_baud_gen_chk (
  input logic       clk,
  input logic       rst,
  input logic [7:0] div_hi,
  input logic [7:0] div_lo,
  input logic       div_hi_we,
  input logic       div_lo_we,
  input logic       pre_div4,
  input logic       sample_tick,
  input logic       bit_tick
);
  logic [4:0] since_bit;

  always_ff @(posedge clk) begin
    if (rst || div_hi_we || div_lo_we || bit_tick) begin
      since_bit <= '0;
    end else if (sample_tick && since_bit != 5'd31) begin
      since_bit <= since_bit + 1'b1;
    end
  end

  // R1: outputs quiet right after a reset edge
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!sample_tick && !bit_tick));

  // R7: a restart suppresses both ticks in the next cycle
  assert_restart_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    (div_hi_we || div_lo_we) |=> (!sample_tick && !bit_tick));

  // R8: bit tick only together with a sample tick
  assert_bit_on_sample_R8: assert property (@(posedge clk) disable iff (rst)
    bit_tick |-> sample_tick);

  // R5: at most 16 sample ticks per bit group
  assert_group_bound_R5: assert property (@(posedge clk) disable iff (rst)
    since_bit <= 5'd15);

  // R4: divisor 0 or 1, no prescaler, no restart: tick on every cycle
  assert_min_divisor_R4: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && !div_hi_we && !div_lo_we && !pre_div4 &&
          div_hi == 8'd0 && div_lo <= 8'd1) |-> sample_tick);
endmodule

bind uart_baud_gen uart_baud_gen_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .div_hi      (div_hi),
  .div_lo      (div_lo),
  .div_hi_we   (div_hi_we),
  .div_lo_we   (div_lo_we),
  .pre_div4    (pre_div4),
  .sample_tick (sample_tick),
  .bit_tick    (bit_tick)
);

// File: tb/uart_baud_gen_tb.sv
module uart_baud_gen_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] div_hi = 8'd0;
  logic [7:0] div_lo = 8'd1;
  logic       div_hi_we = 1'b0;
  logic       div_lo_we = 1'b0;
  logic       pre_div4 = 1'b0;
  logic       os_8x = 1'b0;
  logic       sample_tick;
  logic       bit_tick;

  typedef struct {
    int cyc;
    bit is_bit;
    int req;
  } exp_t;

  exp_t sb[$];
  int   cyc = 0;
  int   checks = 0;
  int   errors = 0;
  bit   armed = 1'b0;
  bit   done = 1'b0;

  always #4 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  uart_baud_gen u_dut (
    .clk         (clk),
    .rst         (rst),
    .div_hi      (div_hi),
    .div_lo      (div_lo),
    .div_hi_we   (div_hi_we),
    .div_lo_we   (div_lo_we),
    .pre_div4    (pre_div4),
    .os_8x       (os_8x),
    .sample_tick (sample_tick),
    .bit_tick    (bit_tick)
  );

  // Monitor: pops an expected tick each time the design produces one
  always @(negedge clk) begin
    if (armed && (sample_tick || bit_tick)) begin
      checks++;
      if (sb.size() == 0) begin
        errors++;
        $display("FAIL R2 spurious tick at cycle %0d: actual s=%0b b=%0b expected none",
                 cyc, sample_tick, bit_tick);
      end else begin
        exp_t e;
        e = sb.pop_front();
        if (!sample_tick || cyc != e.cyc || bit_tick != e.is_bit) begin
          errors++;
          $display("FAIL R%0d tick: actual cycle=%0d s=%0b b=%0b expected cycle=%0d s=1 b=%0b",
                   e.req, cyc, sample_tick, bit_tick, e.cyc, e.is_bit);
        end
      end
    end
  end

  // Driver: writes a configuration and queues the tick schedule it implies
  task automatic run_cfg(input logic [7:0] hi, input logic [7:0] lo, input bit pre,
                         input bit m8, input bit use_hi, input int nticks, input int req);
    int w, per, grp, d;
    @(negedge clk);
    div_hi = hi; div_lo = lo; pre_div4 = pre; os_8x = m8;
    if (use_hi) div_hi_we = 1'b1; else div_lo_we = 1'b1;
    @(posedge clk);
    #1;
    w = cyc;
    div_hi_we = 1'b0; div_lo_we = 1'b0;
    d   = ({hi, lo} == 16'd0) ? 1 : int'({hi, lo});
    per = d * (pre ? 4 : 1);
    grp = m8 ? 8 : 16;
    for (int j = 1; j <= nticks; j++) begin
      exp_t e;
      e.cyc = w + j * per;
      e.is_bit = ((j % grp) == 0);
      e.req = (e.is_bit) ? (m8 ? 6 : 5) : req;
      sb.push_back(e);
    end
    armed = 1'b1;
    wait (sb.size() == 0);
    armed = 1'b0;
  endtask

  initial begin
    repeat (3) begin
      @(negedge clk);
      checks++;
      if (sample_tick !== 1'b0 || bit_tick !== 1'b0) begin
        errors++;
        $display("FAIL R1 reset: actual s=%0b b=%0b expected 0 0", sample_tick, bit_tick);
      end
    end
    @(negedge clk) rst = 1'b0;

    run_cfg(8'h00, 8'h01, 1'b0, 1'b0, 1'b0, 33, 2);  // R2, R5: divisor 1
    run_cfg(8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 20, 4);  // R4: zero acts as one
    run_cfg(8'h00, 8'h01, 1'b1, 1'b0, 1'b0, 20, 3);  // R3: prescaled
    run_cfg(8'h00, 8'h18, 1'b0, 1'b1, 1'b0, 17, 9);  // R9, R6: 0x0018 in 8x
    run_cfg(8'h00, 8'h05, 1'b1, 1'b1, 1'b1, 10, 7);  // R7: high-byte strobe, R3
    run_cfg(8'h00, 8'h03, 1'b0, 1'b0, 1'b1, 18, 7);  // R7: restart mid-stream
    run_cfg(8'h09, 8'h00, 1'b0, 1'b0, 1'b0, 17, 9);  // R9: 0x0900 full width

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual pending=%0d expected 0", sb.size());
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule